// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block takes one input clock and produces one divided output clock. It has no gating of its own. Software programs the division ratio through a 32-bit control word that is written and read over a simple one-cycle port. A divider field of elaboration-time width sits at an elaboration-time bit offset inside that word. Four decodings turn the field into a ratio, and one of them is fixed when the block is built:
- ratio = field + 1
- ratio = field
- ratio = 2^field
- lookup in a parameter table, where a zero entry marks that code as unusable

A new ratio first passes the validity checks and then waits in a staging register. It moves into the running counter only when the current output period ends, so the output never shows a truncated phase. An optional commit bit makes staging explicit: a divider write takes effect only if it carries that bit. The control word also holds an idle-permission bit. It drives the `autoidle_en` output, and its polarity can be inverted at build time.

Top module: `clkdiv_reg`

## Requirements
- R1: With the plus-one decoding, the output period is (field + 1) input cycles. A field of 0 gives the pass-through clock.
- R2: With the direct decoding, the output period equals the field value. Codes below the minimum ratio, including 0, are rejected.
- R3: With the power-of-two decoding, the output period is 2^field input cycles.
- R4: With table decoding, the field indexes the table. Entry i sits at bits [i*DW +: DW]. A code whose entry is zero, or whose index lies past the table, is rejected, and the min/max limits do not apply.
- R5: Outside table decoding, a decoded ratio below MIN_DIV or above MAX_DIV is rejected. A rejected write leaves the running ratio unchanged. MAX_DIV itself is accepted.
- R6: The divider field occupies bits [SHIFT +: FW] of the control word. No other bit changes the ratio.
- R7: When LATCH_EN is set, a divider write is staged only if bit LATCH_POS of the written word is 1. That bit always reads back as 0.
- R8: A newly staged ratio is applied only when the current output period completes. The period in progress finishes with the old ratio.
- R9: For a ratio d ≥ 2, the output is high for floor(d/2) input cycles and low for the rest. For d = 1 the output is the input clock itself.
- R10: `autoidle_en` equals bit AI_POS of the control word, inverted when AI_INV is set.
- R11: After reset the control word is 0 and the running ratio is 1 (pass-through).
- R12: `rd_data` returns the last written control word, with the commit bit cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; also clocks the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Divided output clock |
| autoidle_en | output | 1 | Idle permission after polarity correction |

## Verification
The bench measures every output period and high phase in simulated time. This exposes two classes of bug: an odd ratio that rounds the wrong way and produces a wider high phase, and a ratio of 1 that leaves the output stuck at a constant level. A divisor change is injected in the middle of a period. A design that loads the counter immediately would emit a short period, and the bench expects the old full-length period followed by the new one. Rejected codes are issued to every decoder:
- a zero table entry
- a power-of-two result above the maximum
- a direct code below the minimum
- a plus-one value above the maximum

In each case a faulty design would change the measured period. Divider writes without the commit bit are also checked; a design that ignores the commit rule would switch ratios early.

// File: rtl/divctl_pkg.sv
`timescale 1ns/1ps
package divctl_pkg;

    // Field-to-ratio decoding selected at elaboration
    typedef enum logic [1:0] {
        ENC_MINUS1 = 2'd0,   // ratio = field + 1
        ENC_DIRECT = 2'd1,   // ratio = field
        ENC_POW2   = 2'd2,   // ratio = 2 ** field
        ENC_TABLE  = 2'd3    // ratio = table[field], zero entry invalid
    } div_enc_e;

endpackage

// File: rtl/divctl_decode.sv
`timescale 1ns/1ps
module divctl_decode
    import divctl_pkg::*;
#(
    parameter div_enc_e             ENC     = ENC_MINUS1,
    parameter int unsigned          FW      = 4,
    parameter int unsigned          DW      = 8,
    parameter int unsigned          MIN_DIV = 1,
    parameter int unsigned          MAX_DIV = 16,
    parameter int unsigned          TBL_N   = 8,
    parameter logic [TBL_N*DW-1:0]  TABLE   = '0
) (
    input  logic [FW-1:0] field,
    output logic [DW-1:0] div,
    output logic          valid
);

    generate
        if (ENC == ENC_TABLE) begin : g_table
            logic [DW-1:0] entry [TBL_N];

            for (genvar i = 0; i < TBL_N; i++) begin : g_entry
                assign entry[i] = TABLE[i*DW +: DW];
            end

            always_comb begin
                div   = '0;
                valid = 1'b0;
                if (32'(field) < TBL_N) begin
                    div   = entry[field];
                    valid = (div != '0);
                end
            end
        end else begin : g_arith
            logic [31:0] raw;

            if (ENC == ENC_MINUS1) begin : g_minus1
                assign raw = 32'(field) + 32'd1;
            end else if (ENC == ENC_DIRECT) begin : g_direct
                assign raw = 32'(field);
            end else begin : g_pow2
                assign raw = (32'(field) < 32'd32) ? (32'd1 << field) : 32'd0;
            end

            always_comb begin
                valid = (raw >= MIN_DIV) && (raw <= MAX_DIV);
                div   = raw[DW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/divctl_regs.sv
`timescale 1ns/1ps
module divctl_regs #(
    parameter int unsigned DW        = 8,
    parameter bit          LATCH_EN  = 1'b0,
    parameter int unsigned LATCH_POS = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic [DW-1:0] dec_div,
    input  logic          dec_valid,
    output logic [31:0]   ctrl,
    output logic [DW-1:0] pend_div
);

    localparam logic [31:0] COMMIT_MASK = LATCH_EN ? (32'd1 << LATCH_POS) : 32'd0;

    typedef struct packed {
        logic [31:0]   ctrl;
        logic [DW-1:0] pend;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  commit;

    always_comb begin
        nxt_d  = cur_q;
        commit = LATCH_EN ? wr_data[LATCH_POS] : 1'b1;
        if (wr_en) begin
            nxt_d.ctrl = wr_data & ~COMMIT_MASK;
            if (commit && dec_valid) begin
                nxt_d.pend = dec_div;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.ctrl <= '0;
            cur_q.pend <= DW'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ctrl     = cur_q.ctrl;
    assign pend_div = cur_q.pend;

endmodule

// File: rtl/divctl_gen.sv
`timescale 1ns/1ps
module divctl_gen #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pend_div,
    output logic [DW-1:0] div_act,
    output logic [DW-1:0] div_cnt,
    output logic          clk_out
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] act;
        logic          ph;
    } gen_t;

    gen_t cur_q, nxt_d;
    logic last;

    always_comb begin
        nxt_d = cur_q;
        last  = (cur_q.cnt == cur_q.act - 1'b1);
        if (last) begin
            // period boundary: pick up staged ratio here only
            nxt_d.cnt = '0;
            nxt_d.act = pend_div;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        nxt_d.ph = (nxt_d.cnt < (nxt_d.act >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt <= '0;
            cur_q.act <= DW'(1);
            cur_q.ph  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clk_out = (cur_q.act == DW'(1)) ? clk : cur_q.ph;
    assign div_act = cur_q.act;
    assign div_cnt = cur_q.cnt;

endmodule

// File: rtl/clkdiv_reg.sv
`timescale 1ns/1ps
module clkdiv_reg
    import divctl_pkg::*;
#(
    parameter div_enc_e             ENC       = ENC_MINUS1,
    parameter int unsigned          SHIFT     = 0,
    parameter int unsigned          FW        = 4,
    parameter int unsigned          DW        = 8,
    parameter int unsigned          MIN_DIV   = 1,
    parameter int unsigned          MAX_DIV   = 16,
    parameter int unsigned          TBL_N     = 8,
    parameter logic [TBL_N*DW-1:0]  TABLE     = 64'h0506_0003_1000_0804,
    parameter bit                   LATCH_EN  = 1'b0,
    parameter int unsigned          LATCH_POS = 31,
    parameter int unsigned          AI_POS    = 30,
    parameter bit                   AI_INV    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_out,
    output logic        autoidle_en
);

    logic [FW-1:0] wr_field;
    logic [DW-1:0] dec_div;
    logic          dec_valid;
    logic [31:0]   ctrl;
    logic [DW-1:0] pend_div;
    logic [DW-1:0] div_act;
    logic [DW-1:0] div_cnt;

    assign wr_field = wr_data[SHIFT +: FW];

    divctl_decode #(
        .ENC(ENC), .FW(FW), .DW(DW), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .TBL_N(TBL_N), .TABLE(TABLE)
    ) u_dec (
        .field (wr_field),
        .div   (dec_div),
        .valid (dec_valid)
    );

    divctl_regs #(
        .DW(DW), .LATCH_EN(LATCH_EN), .LATCH_POS(LATCH_POS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dec_div   (dec_div),
        .dec_valid (dec_valid),
        .ctrl      (ctrl),
        .pend_div  (pend_div)
    );

    divctl_gen #(
        .DW(DW)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_div (pend_div),
        .div_act  (div_act),
        .div_cnt  (div_cnt),
        .clk_out  (clk_out)
    );

    assign rd_data     = ctrl;
    assign autoidle_en = ctrl[AI_POS] ^ AI_INV;

endmodule

// File: rtl/clkdiv_reg_chk.sv
`timescale 1ns/1ps
module clkdiv_reg_chk
    import divctl_pkg::*;
#(
    parameter div_enc_e    ENC       = ENC_MINUS1,
    parameter int unsigned DW        = 8,
    parameter int unsigned MIN_DIV   = 1,
    parameter int unsigned MAX_DIV   = 16,
    parameter bit          LATCH_EN  = 1'b0,
    parameter int unsigned LATCH_POS = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [31:0]   wr_data,
    input logic [31:0]   rd_data,
    input logic [DW-1:0] div_act,
    input logic [DW-1:0] div_cnt,
    input logic [DW-1:0] pend_div
);

    localparam logic [DW-1:0] MIN_V = DW'(MIN_DIV);
    localparam logic [DW-1:0] MAX_V = DW'(MAX_DIV);
    localparam logic [31:0]   COMMIT_MASK = LATCH_EN ? (32'd1 << LATCH_POS) : 32'd0;

    // R8
    ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> ($past(div_cnt) == ($past(div_act) - 1'b1)));

    // R9
    count_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < div_act);

    // R4
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_act != '0);

    // R5
    ratio_in_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ENC == ENC_TABLE) || (div_act == DW'(1)) ||
        ((div_act >= MIN_V) && (div_act <= MAX_V)));

    // R7
    staged_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (!LATCH_EN || wr_data[LATCH_POS])) |=> $stable(pend_div));

    // R12
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & ~COMMIT_MASK)));

endmodule

bind clkdiv_reg clkdiv_reg_chk #(
    .ENC(ENC), .DW(DW), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .LATCH_EN(LATCH_EN), .LATCH_POS(LATCH_POS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .div_act  (div_act),
    .div_cnt  (div_cnt),
    .pend_div (pend_div)
);

// File: tb/sim_clkdiv_reg.sv
`timescale 1ns/1ps
module sim_clkdiv_reg;
    import divctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wr_en = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd [4];
    logic [3:0]  co;
    logic [3:0]  ai;
    logic [1:0]  sel = 2'd0;
    logic        mclk;
    logic        arm = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    per;
        int    hi;
        int    div;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t cur_e;
    time  rise_t = 0;
    time  fall_t = 0;
    bit   armed_rise = 1'b0;
    bit   have_fall = 1'b0;

    always #5 clk = ~clk;

    // plus-one decoding, field at [7:4], max 12, idle bit 0
    clkdiv_reg #(.ENC(ENC_MINUS1), .SHIFT(4), .FW(4), .MAX_DIV(12), .AI_POS(0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wr_data(wr_data),
        .rd_data(rd[0]), .clk_out(co[0]), .autoidle_en(ai[0]));

    // direct decoding with commit bit 31, field at [11:8], limits 2..12, inverted idle bit 1
    clkdiv_reg #(.ENC(ENC_DIRECT), .SHIFT(8), .FW(4), .MIN_DIV(2), .MAX_DIV(12),
                 .LATCH_EN(1'b1), .LATCH_POS(31), .AI_POS(1), .AI_INV(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .wr_data(wr_data),
        .rd_data(rd[1]), .clk_out(co[1]), .autoidle_en(ai[1]));

    // power-of-two decoding, field at [2:0], max 16
    clkdiv_reg #(.ENC(ENC_POW2), .SHIFT(0), .FW(3), .MAX_DIV(16)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[2]), .wr_data(wr_data),
        .rd_data(rd[2]), .clk_out(co[2]), .autoidle_en(ai[2]));

    // table decoding, field at [4:2], entries {4,8,0,16,3,0,6,5}
    clkdiv_reg #(.ENC(ENC_TABLE), .SHIFT(2), .FW(3), .TBL_N(8),
                 .TABLE(64'h0506_0003_1000_0804)) u3 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[3]), .wr_data(wr_data),
        .rd_data(rd[3]), .clk_out(co[3]), .autoidle_en(ai[3]));

    assign mclk = co[sel];

    // monitor: measure each full output period and compare with the scoreboard
    always @(posedge mclk) begin
        if (arm && armed_rise && have_fall && q.size() != 0) begin
            cur_e = q.pop_front();
            checks++;
            if (($time - rise_t) != cur_e.per || (fall_t - rise_t) != cur_e.hi) begin
                errors++;
                $display("FAIL %s div %0d: actual period %0d high %0d, expected period %0d high %0d",
                         cur_e.req, cur_e.div, $time - rise_t, fall_t - rise_t, cur_e.per, cur_e.hi);
            end
        end
        rise_t     = $time;
        armed_rise = arm;
        have_fall  = 1'b0;
    end

    always @(negedge mclk) begin
        fall_t    = $time;
        have_fall = 1'b1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check_val(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en   = 4'(1 << idx);
        @(negedge clk);
        wr_en   = '0;
    endtask

    task automatic push(int d, string req);
        exp_t e;
        e.per = d * 10;
        e.hi  = (d == 1) ? 5 : (d / 2) * 10;
        e.div = d;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        while (q.size() != 0) begin
            exp_t e = q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: actual no output edges, expected period %0d", e.req, e.per);
        end
    endtask

    task automatic expect_div(int idx, int d, int n, string req);
        sel = 2'(idx);
        repeat (40) @(negedge clk);
        arm = 1'b1;
        for (int i = 0; i < n; i++) push(d, req);
        drain();
        arm = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual run still active, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        for (int i = 0; i < 4; i++) check_val("R11", "control word after reset", rd[i], 0);
        check_val("R11", "idle outputs after reset", ai, 4'b0010);
        expect_div(0, 1, 3, "R11 R9 pass-through");

        // u0: plus-one decoding
        wr(0, 32'h50);
        expect_div(0, 6, 3, "R1");
        wr(0, 32'h5F);
        check_val("R10", "idle bit set", ai[0], 1);
        expect_div(0, 6, 2, "R6 non-field bits");
        // R8: change in mid-period; old period completes first
        sel = 2'd0;
        repeat (40) @(negedge clk);
        arm = 1'b1;
        push(6, "R8 old period");
        push(4, "R8 new period");
        push(4, "R8 new period");
        @(posedge mclk);
        @(negedge clk);
        wr(0, 32'h30);
        drain();
        arm = 1'b0;
        wr(0, 32'h40);
        expect_div(0, 5, 3, "R9 odd ratio");
        wr(0, 32'hD0);
        check_val("R12", "readback after rejected write", rd[0], 32'hD0);
        expect_div(0, 5, 2, "R5 above max kept");
        wr(0, 32'hB0);
        expect_div(0, 12, 2, "R5 max accepted");

        // u1: direct decoding with commit bit
        wr(1, 32'h0000_0600);
        check_val("R12", "readback staged word", rd[1], 32'h0000_0600);
        expect_div(1, 1, 2, "R7 no commit");
        wr(1, 32'h8000_0600);
        check_val("R7", "commit bit reads zero", rd[1], 32'h0000_0600);
        expect_div(1, 6, 2, "R7 committed");
        wr(1, 32'h8000_0100);
        expect_div(1, 6, 2, "R2 below min kept");
        wr(1, 32'h8000_0000);
        expect_div(1, 6, 2, "R2 zero code kept");
        wr(1, 32'h8000_0D00);
        expect_div(1, 6, 2, "R5 direct above max kept");
        wr(1, 32'h8000_0700);
        expect_div(1, 7, 3, "R2 R9 direct odd");
        check_val("R10", "inverted idle with bit clear", ai[1], 1);
        wr(1, 32'h0000_0702);
        check_val("R10", "inverted idle with bit set", ai[1], 0);

        // u2: power-of-two decoding
        wr(2, 32'h3);
        expect_div(2, 8, 2, "R3");
        wr(2, 32'h2);
        expect_div(2, 4, 3, "R3");
        wr(2, 32'h5);
        expect_div(2, 4, 2, "R5 pow2 above max kept");
        wr(2, 32'h0);
        expect_div(2, 1, 3, "R3 zero code pass-through");

        // u3: table decoding
        wr(3, 32'h4);
        expect_div(3, 8, 2, "R4 entry 1");
        wr(3, 32'h10);
        expect_div(3, 3, 3, "R4 entry 4");
        wr(3, 32'h8);
        expect_div(3, 3, 2, "R4 zero entry kept");
        wr(3, 32'h18);
        expect_div(3, 6, 2, "R4 entry 6");
        wr(3, 32'h0);
        expect_div(3, 4, 2, "R4 entry 0");

        finish_run();
    end

endmodule